// File: doc/BRIEF.md
# Serial Interrupt Collector with Acknowledge Precedence

This block gathers interrupt events from the serial channels and the counter/timer of a serial subsystem into a sticky status register. A mask register selects which of these sources may raise the general request. Software reads both registers through a small register port. It clears status bits by writing ones to the status register.

Two active-low request lines leave the block. The general request goes low when at least one status bit is set and enabled by its mask bit. The timer request is the inverted counter/timer-ready status bit, gated by an enable bit held outside the block. Both lines are registered.

The block also answers interrupt acknowledge cycles. If the acknowledged level equals the programmed level and an enabled source is pending, the block claims the cycle. That claim takes precedence over an external request sharing the same level. Otherwise the external source is granted. The priority encoder on the processor side lies outside this block.

Top module: `sio_irq_hub`

## Requirements
- R1: While reset is held and in the cycles after its release, with no stimulus, both request outputs are 1, both acknowledge outputs are 0, and the status and mask registers read 0.
- R2: A 1 on src_set[i] at a clock edge sets status bit i, which stays set until cleared. A write with reg_sel=1 clears each status bit whose wdata bit is 1. In the same cycle a set wins over a clear.
- R3: A write with reg_sel=0 loads wdata into the mask register. Bit i of the mask enables status bit i (1 = enabled).
- R4: A read with reg_sel=1 returns all status bits unmasked, and a read with reg_sel=0 returns the mask. rdata is combinational from the selected register.
- R5: irq_n is 0 exactly one clock after a cycle in which (status AND mask) is nonzero, and 1 otherwise.
- R6: tirq_n is 0 exactly one clock after a cycle in which status bit TMR_BIT (default 3) is set and tmr_en is 1, and 1 otherwise. The mask has no effect on tirq_n.
- R7: If iack=1, iack_lvl equals irq_lvl and (status AND mask) is nonzero, then ack_mod is 1 for the next cycle and ack_ext is 0, even if ext_req=1.
- R8: If iack=1 and iack_lvl equals irq_lvl but no enabled source is pending, then ack_mod is 0 and ack_ext equals ext_req in the next cycle.
- R9: If iack=0, or if iack_lvl differs from irq_lvl, then both ack_mod and ack_ext are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | NSRC | Per-source set strobes |
| wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = mask, 1 = status |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data of the selected register |
| tmr_en | input | 1 | External timer request enable |
| irq_lvl | input | LVL_W | Programmed request level |
| iack | input | 1 | Acknowledge strobe |
| iack_lvl | input | LVL_W | Level being acknowledged |
| ext_req | input | 1 | External request pending at the shared level |
| irq_n | output | 1 | General request, active low |
| tirq_n | output | 1 | Timer request, active low |
| ack_mod | output | 1 | Cycle claimed by this block |
| ack_ext | output | 1 | Cycle passed to the external source |

## Verification
Random cycles mix sparse set strobes, write-one-to-clear writes, mask loads and acknowledges at a matching or mismatching level. These cycles separate a general request caused by an enabled bit from one caused by a masked bit. They also separate claiming the cycle from passing it on. Directed cases cover the following:
- a set and a clear of the same bit in one cycle;
- a status read with all sources masked;
- the timer request with its enable off;
- an acknowledge with ext_req high while an enabled source is pending and while none is.

Together these show that precedence depends on the pending state and not only on ext_req.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic            wr,
  input  logic            reg_sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] mask_q
);
  logic wr_stat;
  logic wr_mask;
  logic [NSRC-1:0] mask_d;

  always_comb begin
    wr_stat = wr && (reg_sel_e'(reg_sel) == SEL_STAT);
    wr_mask = wr && (reg_sel_e'(reg_sel) == SEL_MASK);
    mask_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_en;
    logic bit_d;
    always_comb begin
      bit_en = src_set[i] || (wr_stat && wdata[i]);
      bit_d  = src_set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else if (bit_en) stat_q[i] <= bit_d;
    end
  end
endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req #(
  parameter int NSRC    = 8,
  parameter int TMR_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic            tmr_en,
  output logic            pend,
  output logic            irq_n,
  output logic            tirq_n
);
  logic irq_n_d;
  logic tirq_n_d;

  always_comb begin
    pend     = |(stat_q & mask_q);
    irq_n_d  = ~pend;
    tirq_n_d = ~(stat_q[TMR_BIT] & tmr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n  <= 1'b1;
      tirq_n <= 1'b1;
    end else begin
      irq_n  <= irq_n_d;
      tirq_n <= tirq_n_d;
    end
  end
endmodule

// File: rtl/sio_irq_arb.sv
module sio_irq_arb #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_lvl,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic             pend,
  input  logic             ext_req,
  output logic             ack_mod,
  output logic             ack_ext
);
  logic hit;
  logic mod_d;
  logic ext_d;

  always_comb begin
    hit   = iack && (iack_lvl == irq_lvl);
    mod_d = hit && pend;
    ext_d = hit && !pend && ext_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_mod <= 1'b0;
      ack_ext <= 1'b0;
    end else begin
      ack_mod <= mod_d;
      ack_ext <= ext_d;
    end
  end
endmodule

// File: rtl/sio_irq_hub.sv
module sio_irq_hub
  import sio_irq_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int TMR_BIT = 3,
  parameter int LVL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_set,
  input  logic             wr,
  input  logic             reg_sel,
  input  logic [NSRC-1:0]  wdata,
  output logic [NSRC-1:0]  rdata,
  input  logic             tmr_en,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_lvl,
  input  logic             ext_req,
  output logic             irq_n,
  output logic             tirq_n,
  output logic             ack_mod,
  output logic             ack_ext
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q;
  logic [NSRC-1:0]        stat_q;
  logic [NSRC-1:0]        mask_q;
  logic                   pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_sync_q[SYNC_STAGES-1];

  sio_irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_q), .src_set(src_set), .wr(wr), .reg_sel(reg_sel),
    .wdata(wdata), .stat_q(stat_q), .mask_q(mask_q)
  );

  sio_irq_req #(.NSRC(NSRC), .TMR_BIT(TMR_BIT)) u_req (
    .clk(clk), .rst_n(rst_q), .stat_q(stat_q), .mask_q(mask_q), .tmr_en(tmr_en),
    .pend(pend), .irq_n(irq_n), .tirq_n(tirq_n)
  );

  sio_irq_arb #(.LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_q), .iack(iack), .iack_lvl(iack_lvl), .irq_lvl(irq_lvl),
    .pend(pend), .ext_req(ext_req), .ack_mod(ack_mod), .ack_ext(ack_ext)
  );

  always_comb begin
    rdata = (reg_sel_e'(reg_sel) == SEL_STAT) ? stat_q : mask_q;
  end
endmodule

// File: rtl/sio_irq_hub_chk.sv
module sio_irq_hub_chk #(
  parameter int NSRC    = 8,
  parameter int TMR_BIT = 3,
  parameter int LVL_W   = 3
) (
  input logic             clk,
  input logic             rst_q,
  input logic [NSRC-1:0]  src_set,
  input logic [NSRC-1:0]  stat_q,
  input logic [NSRC-1:0]  mask_q,
  input logic             tmr_en,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             iack,
  input logic [LVL_W-1:0] iack_lvl,
  input logic             irq_n,
  input logic             tirq_n,
  input logic             ack_mod,
  input logic             ack_ext
);
  assert_set_sticky_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (src_set != '0) |=> ((stat_q & $past(src_set)) == $past(src_set)));

  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (irq_n == ($past(stat_q & mask_q) == '0)));

  assert_tirq_follow_R6: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (tirq_n == !($past(stat_q[TMR_BIT]) && $past(tmr_en))));

  assert_claim_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (iack && (iack_lvl == irq_lvl) && ((stat_q & mask_q) != '0)) |=> (ack_mod && !ack_ext));

  assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ack_mod, ack_ext}));

  assert_mismatch_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (!iack || (iack_lvl != irq_lvl)) |=> (!ack_mod && !ack_ext));
endmodule

bind sio_irq_hub sio_irq_hub_chk #(.NSRC(NSRC), .TMR_BIT(TMR_BIT), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .src_set(src_set), .stat_q(stat_q), .mask_q(mask_q),
  .tmr_en(tmr_en), .irq_lvl(irq_lvl), .iack(iack), .iack_lvl(iack_lvl),
  .irq_n(irq_n), .tirq_n(tirq_n), .ack_mod(ack_mod), .ack_ext(ack_ext)
);

// File: tb/sio_irq_hub_bench.sv
`timescale 1ns/1ps
module sio_irq_hub_bench;
  localparam int NSRC = 8;
  localparam int TB   = 3;
  localparam int LW   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src_set, wdata, rdata;
  logic wr, reg_sel, tmr_en, iack, ext_req;
  logic [LW-1:0] irq_lvl, iack_lvl;
  logic irq_n, tirq_n, ack_mod, ack_ext;

  int checks = 0;
  int errors = 0;
  logic [NSRC-1:0] m_stat = '0;
  logic [NSRC-1:0] m_mask = '0;

  always #4 clk = ~clk;

  sio_irq_hub u_sio_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr(wr), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .tmr_en(tmr_en), .irq_lvl(irq_lvl), .iack(iack),
    .iack_lvl(iack_lvl), .ext_req(ext_req), .irq_n(irq_n), .tirq_n(tirq_n),
    .ack_mod(ack_mod), .ack_ext(ack_ext)
  );

  task automatic chk(input string req, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NSRC-1:0] next_stat(input logic [NSRC-1:0] s, input logic [NSRC-1:0] set,
                                                input logic w, input logic sel, input logic [NSRC-1:0] d);
    logic [NSRC-1:0] r = s;
    if (w && sel) r = r & ~d;
    return r | set;
  endfunction

  // one clock cycle: drive at negedge, expectations from the pre-edge model, sample after the edge
  task automatic step(input logic [NSRC-1:0] set, input logic w, input logic sel,
                      input logic [NSRC-1:0] d, input logic ia, input logic [LW-1:0] il,
                      input logic ex, input logic te);
    logic e_irq, e_tirq, e_mod, e_ext, hit, pend;
    @(negedge clk);
    src_set = set; wr = w; reg_sel = sel; wdata = d;
    iack = ia; iack_lvl = il; ext_req = ex; tmr_en = te;
    pend   = |(m_stat & m_mask);
    hit    = ia && (il == irq_lvl);
    e_irq  = !pend;
    e_tirq = !(m_stat[TB] && te);
    e_mod  = hit && pend;
    e_ext  = hit && !pend && ex;
    m_stat = next_stat(m_stat, set, w, sel, d);
    if (w && !sel) m_mask = d;
    @(posedge clk);
    #2;
    chk("R5 irq_n", NSRC'(irq_n), NSRC'(e_irq));
    chk("R6 tirq_n", NSRC'(tirq_n), NSRC'(e_tirq));
    chk(hit ? (pend ? "R7 ack_mod" : "R8 ack_mod") : "R9 ack_mod", NSRC'(ack_mod), NSRC'(e_mod));
    chk(hit ? (pend ? "R7 ack_ext" : "R8 ack_ext") : "R9 ack_ext", NSRC'(ack_ext), NSRC'(e_ext));
    chk(sel ? "R2/R4 status read" : "R3 mask read", rdata, sel ? m_stat : m_mask);
  endtask

  task automatic idle();
    step('0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    rst_n = 1'b0; src_set = '0; wr = 1'b0; reg_sel = 1'b1; wdata = '0;
    tmr_en = 1'b0; irq_lvl = 3'd5; iack = 1'b0; iack_lvl = '0; ext_req = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 irq_n in reset", NSRC'(irq_n), NSRC'(1'b1));
    chk("R1 tirq_n in reset", NSRC'(tirq_n), NSRC'(1'b1));
    chk("R1 acks in reset", NSRC'({ack_mod, ack_ext}), '0);
    chk("R1 status in reset", rdata, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle();

    // R2: set and clear of the same bit in one cycle, set wins
    step(8'h01, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
    step(8'h01, 1'b1, 1'b1, 8'h01, 1'b0, '0, 1'b0, 1'b0);
    chk("R2 set beats clear", rdata, 8'h01);
    step('0, 1'b1, 1'b1, 8'h01, 1'b0, '0, 1'b0, 1'b0);
    chk("R2 clear", rdata, 8'h00);
    // R4: status read unmasked with everything masked
    step(8'hA8, 1'b1, 1'b0, 8'h00, 1'b0, '0, 1'b0, 1'b1);
    step('0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, 1'b1);
    chk("R4 unmasked read", rdata, 8'hA8);
    chk("R5 masked stays high", NSRC'(irq_n), NSRC'(1'b1));
    chk("R6 timer ignores mask", NSRC'(tirq_n), NSRC'(1'b0));
    // R6: enable off
    step('0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
    chk("R6 enable off", NSRC'(tirq_n), NSRC'(1'b1));
    // R8: no enabled pending, ext wins
    step('0, 1'b0, 1'b1, '0, 1'b1, 3'd5, 1'b1, 1'b0);
    chk("R8 ext granted", NSRC'(ack_ext), NSRC'(1'b1));
    // R7: enable bit 5, module claims over ext
    step('0, 1'b1, 1'b0, 8'h20, 1'b0, '0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1, '0, 1'b1, 3'd5, 1'b1, 1'b0);
    chk("R7 module claims", NSRC'(ack_mod), NSRC'(1'b1));
    // R9: level mismatch
    step('0, 1'b0, 1'b1, '0, 1'b1, 3'd7, 1'b1, 1'b0);
    chk("R9 mismatch", NSRC'({ack_mod, ack_ext}), '0);

    for (int n = 0; n < 600; n++) begin
      logic [NSRC-1:0] set;
      logic w, sel, ia;
      logic [LW-1:0] il;
      set = ($urandom % 4 == 0) ? NSRC'(1 << ($urandom % NSRC)) : '0;
      w   = ($urandom % 3 == 0);
      sel = $urandom % 2;
      ia  = ($urandom % 3 == 0);
      il  = ($urandom % 2) ? irq_lvl : LW'($urandom);
      step(set, w, sel, NSRC'($urandom), ia, il, 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule